// File: doc/BRIEF.md
# Serial Write-Enable Latch Front End

This block sits at the serial-slave edge of a nonvolatile memory. It watches the four serial pins (active-low chip select, serial clock, serial data in, serial data out) and oversamples them in the system clock domain. It captures the first byte of each frame as the command code and keeps a single write-enable latch. Downstream command logic may only carry out a modifying command while that latch is set. As a result, every program, erase, protection or status-write operation takes two steps: first a frame that sets the latch, then the command itself.

The latch reacts to two command codes. 06h sets it and 04h clears it. The change takes effect only when chip select returns high. It also requires that the frame held a whole number of bytes, with at least one byte present. A frame that ends part-way through a byte is thrown away. Bytes that follow the command code are ignored, but they still count toward the byte-alignment rule. The block presents the decoded code, a grant or refusal for modifying commands, and a drive enable for the serial output.

Top module: `wel_guard`

## Requirements
- R1: After reset, and while reset is held, `wel`, `opcodeValid`, `modifyPermit`, `modifyReject` and `sdoEn` are all 0.
- R2: A frame whose first byte is 06h, with a total bit count that is a nonzero multiple of 8, sets `wel` to 1 once chip select rises.
- R3: A frame whose first byte is 04h, with a total bit count that is a nonzero multiple of 8, clears `wel` to 0 once chip select rises.
- R4: `wel` does not change while chip select stays low, even after the complete command byte has been shifted in.
- R5: A frame whose bit count is zero or not a multiple of 8 leaves `wel` unchanged, whatever its first bits are.
- R6: Bits that follow the command byte are ignored; they do not affect `opcode` or the result, provided the frame ends on a byte boundary.
- R7: Data is sampled on rising serial-clock edges, most significant bit first. After the eighth bit, `opcode` holds the first byte, with the first bit received in bit 7, and `opcodeValid` is 1 until chip select rises.
- R8: Command codes other than 06h and 04h leave `wel` unchanged.
- R9: The modifying command codes are 02h, 20h, 52h, D8h, 60h, C7h, 36h, 39h, 33h, 34h, 9Bh and 01h. While one of them is the captured code and chip select is low, `modifyPermit` is 1 if `wel` is 1 and `modifyReject` is 1 if `wel` is 0. Otherwise both are 0.
- R10: `sdoEn` is 0 while chip select is high, before a command byte is complete, and for 06h, 04h and the modifying codes. It is 1 for any other captured code while chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data in, most significant bit first |
| sdoEn | output | 1 | Drive enable for serial data out (0 = high impedance) |
| opcode | output | 8 | First byte of the current frame |
| opcodeValid | output | 1 | First byte complete in the current frame |
| wel | output | 1 | Write-enable latch |
| modifyPermit | output | 1 | Captured modifying command may proceed |
| modifyReject | output | 1 | Captured modifying command is refused |

## Verification
The bench drives frames of 7 and 9 bits. A design that compared only the bit count mod 8 at the command byte, or that committed on the eighth bit, would change the latch on these frames. It also sends 16- and 24-bit frames with trailing bytes: a design that decoded the last byte instead of the first, or that required exactly eight bits, would fail to set or clear the latch. An empty chip-select pulse checks that an idle counter at zero is not mistaken for alignment. Mid-frame samples catch a latch that updates before chip select rises, and modifying codes sent with the latch in each state catch a reversed or ungated permit.

// File: rtl/wel_pkg.sv
package wel_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_SET_LATCH = 8'h06;
  localparam logic [BYTE_W-1:0] OP_CLR_LATCH = 8'h04;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_LATCH  = 2'd1,
    CMD_MODIFY = 2'd2,
    CMD_OTHER  = 2'd3
  } cmd_class_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleBit;   // rising serial clock inside an active frame
    logic frameClear;  // chip select returned high
  } wel_strobe_t;

  function automatic logic isModifyOp(input logic [BYTE_W-1:0] op);
    case (op)
      8'h02, 8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7,
      8'h36, 8'h39, 8'h33, 8'h34, 8'h9B, 8'h01: isModifyOp = 1'b1;
      default:                                 isModifyOp = 1'b0;
    endcase
  endfunction

  function automatic cmd_class_t classifyOp(input logic valid,
                                            input logic [BYTE_W-1:0] op);
    if (!valid)
      classifyOp = CMD_NONE;
    else if (op == OP_SET_LATCH || op == OP_CLR_LATCH)
      classifyOp = CMD_LATCH;
    else if (isModifyOp(op))
      classifyOp = CMD_MODIFY;
    else
      classifyOp = CMD_OTHER;
  endfunction

endpackage

// File: rtl/wel_pin_sync.sv
module wel_pin_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut
);

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RST_VAL;
          else       chain[s] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= RST_VAL;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pinOut = chain[STAGES-1];

endmodule

// File: rtl/wel_datapath.sv
module wel_datapath
  import wel_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wel_strobe_t       stb,
  input  logic              sdiS,
  output logic [DATA_W-1:0] opcode,
  output logic              opcodeValid,
  output logic              aligned
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] shiftNext;
  logic [CNT_W-1:0]  bitCnt;
  logic              byteSeen;

  assign shiftNext = {shiftReg[DATA_W-2:0], sdiS};
  assign aligned   = byteSeen && (bitCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      bitCnt      <= '0;
      byteSeen    <= 1'b0;
      opcode      <= '0;
      opcodeValid <= 1'b0;
    end else if (stb.frameClear) begin
      shiftReg    <= '0;
      bitCnt      <= '0;
      byteSeen    <= 1'b0;
      opcodeValid <= 1'b0;
    end else if (stb.sampleBit) begin
      shiftReg <= shiftNext;
      if (bitCnt == LAST_BIT) begin
        bitCnt   <= '0;
        byteSeen <= 1'b1;
        if (!opcodeValid) begin
          opcode      <= shiftNext;
          opcodeValid <= 1'b1;
        end
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R7: the eighth bit of the first byte completes the command code
  assert_opcode_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sampleBit && !stb.frameClear && !opcodeValid && bitCnt == LAST_BIT)
      |=> opcodeValid);

  // R6: later bytes never overwrite the captured code
  assert_trailing_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opcodeValid && !stb.frameClear) |=> $stable(opcode));

  // R5: alignment is only claimed after a full byte
  assert_aligned_needs_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    aligned |-> opcodeValid);

endmodule

// File: rtl/wel_ctrl.sv
module wel_ctrl
  import wel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csS,
  input  logic              sckS,
  input  logic [BYTE_W-1:0] opcode,
  input  logic              opcodeValid,
  input  logic              aligned,
  output wel_strobe_t       stb,
  output logic              wel,
  output logic              modifyPermit,
  output logic              modifyReject,
  output logic              sdoEn
);

  logic sckPrev;
  logic csPrev;
  logic csActive;
  logic sckRise;
  logic frameEnd;
  cmd_class_t cmdClass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
    end
  end

  assign csActive = !csS;
  assign sckRise  = sckS && !sckPrev;
  assign frameEnd = csS && !csPrev;

  assign stb.sampleBit  = sckRise && csActive;
  assign stb.frameClear = frameEnd;

  // Latch applies only on a byte-aligned close of the frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
    end else if (frameEnd && aligned) begin
      if (opcode == OP_SET_LATCH)      wel <= 1'b1;
      else if (opcode == OP_CLR_LATCH) wel <= 1'b0;
    end
  end

  assign cmdClass     = classifyOp(opcodeValid, opcode);
  assign modifyPermit = csActive && (cmdClass == CMD_MODIFY) && wel;
  assign modifyReject = csActive && (cmdClass == CMD_MODIFY) && !wel;
  assign sdoEn        = csActive && (cmdClass == CMD_OTHER);

  // R4: no latch movement without a frame close
  assert_wel_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(wel));

  // R5: a misaligned close is discarded
  assert_abort_R5: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !aligned) |=> $stable(wel));

  // R2: the latch only rises after a set command
  assert_set_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(opcode == OP_SET_LATCH && opcodeValid));

  // R3: the latch only falls after a clear command
  assert_clr_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wel) |-> $past(opcode == OP_CLR_LATCH && opcodeValid));

  // R9: grant and refusal are exclusive
  assert_permit_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(modifyPermit && modifyReject));

  // R10: output drive only after a complete command byte
  assert_sdo_needs_opcode_R10: assert property (@(posedge clk) disable iff (!rstN)
    sdoEn |-> opcodeValid);

endmodule

// File: rtl/wel_guard.sv
module wel_guard
  import wel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdoEn,
  output logic [BYTE_W-1:0] opcode,
  output logic              opcodeValid,
  output logic              wel,
  output logic              modifyPermit,
  output logic              modifyReject
);

  logic [2:0]  pinSync;
  wel_strobe_t stb;
  logic        aligned;

  wel_pin_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn ({csN, sck, sdi}),
    .pinOut(pinSync)
  );

  wel_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .csS         (pinSync[2]),
    .sckS        (pinSync[1]),
    .opcode      (opcode),
    .opcodeValid (opcodeValid),
    .aligned     (aligned),
    .stb         (stb),
    .wel         (wel),
    .modifyPermit(modifyPermit),
    .modifyReject(modifyReject),
    .sdoEn       (sdoEn)
  );

  wel_datapath #(
    .DATA_W(BYTE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .sdiS       (pinSync[0]),
    .opcode     (opcode),
    .opcodeValid(opcodeValid),
    .aligned    (aligned)
  );

endmodule

// File: tb/wel_guard_bench.sv
module wel_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK = 4;
  localparam int NVEC = 13;

  typedef struct packed {
    logic [23:0] bits;    // right-aligned, sent MSB first
    logic [4:0]  nbits;
    logic        expWel;
    logic        expSdo;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{24'h000006,  5'd8,  1'b1, 1'b0},  // R2 set
    '{24'h000004,  5'd8,  1'b0, 1'b0},  // R3 clear
    '{24'h000003,  5'd7,  1'b0, 1'b0},  // R5 7-bit 06h
    '{24'h000006,  5'd8,  1'b1, 1'b0},  // R2 set again
    '{24'h000009,  5'd9,  1'b1, 1'b0},  // R5 9-bit 04h
    '{24'h000002,  5'd7,  1'b1, 1'b0},  // R5 7-bit 04h
    '{24'h0004FF,  5'd16, 1'b0, 1'b0},  // R6 clear with trailing byte
    '{24'h000600,  5'd16, 1'b1, 1'b0},  // R6 set with trailing byte
    '{24'h000005,  5'd8,  1'b1, 1'b1},  // R8 other code
    '{24'h00004A,  5'd12, 1'b1, 1'b0},  // R5 12-bit 04h
    '{24'h04AA55,  5'd24, 1'b0, 1'b0},  // R6 two trailing bytes
    '{24'h000000,  5'd0,  1'b0, 1'b0},  // R5 empty frame
    '{24'h000006,  5'd8,  1'b1, 1'b0}   // R2 set
  };

  logic clk = 1'b0;
  logic rstN, csN, sck, sdi;
  logic sdoEn, opcodeValid, wel, modifyPermit, modifyReject;
  logic [7:0] opcode;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wel_guard u_wel_guard (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .sdoEn(sdoEn), .opcode(opcode), .opcodeValid(opcodeValid),
    .wel(wel), .modifyPermit(modifyPermit), .modifyReject(modifyReject)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csLow();
    csN = 1'b0;
    waitClk(HALF_SCK);
  endtask

  task automatic csHigh();
    waitClk(HALF_SCK);
    csN = 1'b1;
    waitClk(2 * HALF_SCK);
  endtask

  task automatic shiftBits(input logic [23:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      waitClk(HALF_SCK);
      sck = 1'b1;
      waitClk(HALF_SCK);
      sck = 1'b0;
    end
    waitClk(HALF_SCK);
  endtask

  task automatic sendByte(input logic [7:0] b);
    csLow();
    shiftBits({16'h0, b}, 8);
    csHigh();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic expWel;
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; sdi = 1'b0;
    waitClk(5);
    check({wel, opcodeValid, modifyPermit, modifyReject, sdoEn} == 5'b0,
          "R1 in reset", {wel, opcodeValid, modifyPermit, modifyReject, sdoEn}, 0);
    rstN = 1'b1;
    waitClk(4);
    check({wel, opcodeValid, modifyPermit, modifyReject, sdoEn} == 5'b0,
          "R1 after reset", {wel, opcodeValid, modifyPermit, modifyReject, sdoEn}, 0);

    expWel = 1'b0;
    for (int v = 0; v < NVEC; v++) begin
      csLow();
      shiftBits(VECS[v].bits, int'(VECS[v].nbits));
      check(wel == expWel, "R4 latch before frame close", wel, expWel);
      if (VECS[v].nbits >= 8) begin
        check(opcodeValid && opcode == 8'(VECS[v].bits >> (VECS[v].nbits - 5'd8)),
              "R7 captured code", {opcodeValid, opcode},
              {1'b1, 8'(VECS[v].bits >> (VECS[v].nbits - 5'd8))});
        check(sdoEn == VECS[v].expSdo, "R10 drive enable in frame", sdoEn, VECS[v].expSdo);
      end
      csHigh();
      check(wel == VECS[v].expWel, "R2/R3/R5/R6/R8 latch after frame", wel, VECS[v].expWel);
      check(!opcodeValid && !sdoEn, "R10 idle after frame", {opcodeValid, sdoEn}, 0);
      expWel = VECS[v].expWel;
    end

    // R9: modifying code with latch set
    csLow();
    shiftBits(24'h02, 8);
    check(modifyPermit && !modifyReject, "R9 permit with latch set",
          {modifyPermit, modifyReject}, 2'b10);
    check(!sdoEn, "R10 no drive for modifying code", sdoEn, 0);
    csHigh();
    check(wel == 1'b1, "R8 modifying code leaves latch", wel, 1);
    check(!modifyPermit && !modifyReject, "R9 no grant with chip select high",
          {modifyPermit, modifyReject}, 0);

    // R9: modifying code with latch clear
    sendByte(8'h04);
    check(wel == 1'b0, "R3 clear before refusal test", wel, 0);
    csLow();
    shiftBits(24'h9B, 8);
    check(!modifyPermit && modifyReject, "R9 refuse with latch clear",
          {modifyPermit, modifyReject}, 2'b01);
    csHigh();
    check(wel == 1'b0, "R8 refused code leaves latch", wel, 0);

    // R10: partial byte never enables output
    csLow();
    shiftBits(24'h05, 5);
    check(!sdoEn && !opcodeValid, "R10 no drive before byte complete",
          {sdoEn, opcodeValid}, 0);
    csHigh();

    // R1: reset clears a set latch
    sendByte(8'h06);
    check(wel == 1'b1, "R2 set before reset", wel, 1);
    rstN = 1'b0;
    waitClk(1);
    check(wel == 1'b0, "R1 reset clears latch", wel, 0);
    rstN = 1'b1;
    waitClk(4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule